// File: doc/BRIEF.md
# Command Effects Log Generator

This block builds a small log describing every mailbox opcode the device supports, together with the side-effect flags each opcode carries, and serves that log to a command dispatcher. After reset it walks the whole 16-bit opcode space in ascending order, checks each value against a parameterized table of supported commands, and appends a 4-byte entry to an internal log store for every hit, counting entries as it goes.

When the walk is complete the block answers two requests from the dispatcher. The first is a logs-directory query, which writes a fixed 28-byte descriptor into the shared payload RAM. The descriptor carries the log identifier and the log size in bytes. The second is a log read, which takes a 24-byte request header from the payload RAM. The block checks the requested byte range first and the identifier second, then overwrites the payload with the requested slice of the log. Requests that arrive while the walk is still running are rejected with a busy code.

The controller is a single state machine. ST_IDLE waits for a request. ST_SUPP writes the directory descriptor. ST_HDR reads the request header. ST_CHECK applies the range and identifier checks. ST_COPY streams the log bytes out, and ST_RESP pulses the response. The transitions are as follows:
- ST_IDLE goes to ST_RESP on a request made during the walk.
- ST_IDLE goes to ST_SUPP on a directory query.
- ST_IDLE goes to ST_HDR on a log read.
- ST_SUPP goes to ST_RESP after byte 27.
- ST_HDR goes to ST_CHECK once all 24 header bytes are captured.
- ST_CHECK goes to ST_RESP on an error or a zero length, and to ST_COPY otherwise.
- ST_COPY goes to ST_RESP after the last byte.
- ST_RESP always returns to ST_IDLE.

Top module: `cel_log_engine`

## Requirements
- R1: The walk visits opcodes 0x0000 to 0xFFFF in ascending order and stores one entry per supported opcode, in ascending opcode order. Each entry is 4 bytes, little-endian: the opcode in bytes 0–1 and its 16-bit effect field in bytes 2–3.
- R2: A request accepted before the walk has finished completes with code 0x06 and length 0, and performs no payload write.
- R3: The directory query completes with code 0x00 and length 28. It writes payload bytes 0–1 with the entry count 1 (little-endian), bytes 2–7 with zero, bytes 8–23 with the log identifier (byte k of the 128-bit identifier is bits 8k+7..8k), and bytes 24–27 with the log size.
- R4: The reported log size is four times the number of stored entries, little-endian.
- R5: A log read takes its header from payload bytes 0–15 (identifier), 16–19 (offset, little-endian) and 20–23 (length, little-endian).
- R6: If offset plus length, computed without wrap-around, exceeds the payload size (256 bytes), the read completes with code 0x02 and length 0 and leaves the payload unchanged. This check takes priority over the identifier check.
- R7: If the range is acceptable but the identifier differs from the log identifier, the read completes with code 0x03 and length 0 and leaves the payload unchanged.
- R8: A valid read writes log bytes offset to offset+length−1 into payload bytes 0 to length−1 and completes with code 0x00 and a length equal to the requested length. Log bytes at or past 4×count read as zero, and payload bytes at and beyond the requested length are untouched.
- R9: req_ready is high only in the idle state. Every accepted request produces exactly one rsp_valid pulse of one cycle, and no request is accepted in the cycle after one is accepted.
- R10: By default the table holds 13 opcodes with these effect flags: 0x0101 has bit 4 (log change) set (0x10), 0x0103 has bit 1 (configuration change) set (0x02), 0x0301 has bit 3 (policy change) set (0x08), and 0x4103 has bits 1 and 2 (configuration and data change) set (0x06). The others, 0x0100, 0x0102, 0x0200, 0x0300, 0x0400, 0x0401, 0x4000, 0x4100 and 0x4102, have an effect field of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe from the dispatcher |
| req_kind | input | 1 | 0 = logs-directory query, 1 = log read |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_code | output | 8 | Completion code |
| rsp_len | output | 16 | Output payload length in bytes |
| pl_addr | output | PL_AW | Payload RAM byte address |
| pl_rd_en | output | 1 | Payload RAM read enable (data next cycle) |
| pl_rdata | input | 8 | Payload RAM read data |
| pl_wr_en | output | 1 | Payload RAM write enable |
| pl_wdata | output | 8 | Payload RAM write data |

## Verification
The hardest state to reach is a request that lands during the 65,536-cycle opcode walk, and a second one issued right at its end. The bench sends both request kinds immediately after reset and then waits out the walk before the normal traffic starts. The range-before-identifier priority needs requests that are wrong in both ways at once, and range sums that overflow 32 bits. The bench covers these with directed headers. Random reads cover exact-fit ranges, zero lengths and reads past the log end.

// File: rtl/cel_pkg.sv
package cel_pkg;
    localparam int OPC_W      = 16;
    localparam int HDR_BYTES  = 24;
    localparam int SUPP_BYTES = 28;

    localparam logic [7:0] RC_OK        = 8'h00;
    localparam logic [7:0] RC_BAD_INPUT = 8'h02;
    localparam logic [7:0] RC_UNSUPP    = 8'h03;
    localparam logic [7:0] RC_BUSY      = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUPP,
        ST_HDR,
        ST_CHECK,
        ST_COPY,
        ST_RESP
    } cel_state_t;
endpackage

// File: rtl/cel_scanner.sv
module cel_scanner
    import cel_pkg::*;
#(
    parameter int N_CMDS = 13,
    parameter logic [N_CMDS*16-1:0] CMD_OPS = '0,
    parameter logic [N_CMDS*16-1:0] CMD_EFFS = '0,
    parameter int LOG_DEPTH = 16,
    localparam int CW = $clog2(LOG_DEPTH + 1),
    localparam int IW = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   rd_addr,
    output logic [7:0]    rd_byte,
    output logic [CW-1:0] entry_count,
    output logic          scan_done
);
    logic [OPC_W-1:0] scan_op;
    logic [31:0]      log_mem [LOG_DEPTH];
    logic             hit;
    logic [15:0]      hit_eff;
    logic [N_CMDS-1:0] match_vec;

    // one comparator per table row
    for (genvar gi = 0; gi < N_CMDS; gi++) begin : g_match
        assign match_vec[gi] = (CMD_OPS[gi*16 +: 16] == scan_op);
    end

    always_comb begin
        hit     = |match_vec;
        hit_eff = '0;
        for (int i = 0; i < N_CMDS; i++) begin
            if (match_vec[i]) hit_eff = hit_eff | CMD_EFFS[i*16 +: 16];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_op     <= '0;
            scan_done   <= 1'b0;
            entry_count <= '0;
        end else if (!scan_done) begin
            if (hit && (entry_count < CW'(LOG_DEPTH))) begin
                log_mem[entry_count[IW-1:0]] <= {hit_eff, scan_op};
                entry_count <= entry_count + 1'b1;
            end
            scan_op <= scan_op + 1'b1;
            if (scan_op == '1) scan_done <= 1'b1;
        end
    end

    // byte read port: bytes past the stored entries read as zero
    logic [29:0] rd_word;
    logic [31:0] rd_entry;
    assign rd_word = rd_addr[31:2];
    always_comb begin
        rd_entry = '0;
        if (rd_word < 30'(entry_count)) rd_entry = log_mem[rd_word[IW-1:0]];
        rd_byte = rd_entry[{rd_addr[1:0], 3'b000} +: 8];
    end

    AST_COUNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CW'(LOG_DEPTH)); // R1
    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> $stable(entry_count)); // R4
    AST_DONE_STICKY:  assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> scan_done); // R2
endmodule

// File: rtl/cel_responder.sv
module cel_responder
    import cel_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 256,
    parameter logic [127:0] LOG_ID = '0,
    parameter int CW = 5,
    localparam int PL_AW = $clog2(PAYLOAD_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_done,
    input  logic [CW-1:0]    entry_count,
    input  logic             req_valid,
    input  logic             req_kind,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [7:0]       rsp_code,
    output logic [15:0]      rsp_len,
    output logic [PL_AW-1:0] pl_addr,
    output logic             pl_rd_en,
    input  logic [7:0]       pl_rdata,
    output logic             pl_wr_en,
    output logic [7:0]       pl_wdata,
    output logic [31:0]      log_addr,
    input  logic [7:0]       log_byte
);
    cel_state_t state, state_nx;

    logic [31:0]  cnt;
    logic         cap_v;
    logic [4:0]   cap_idx;
    logic [191:0] hdr;

    logic [127:0] hdr_id;
    logic [31:0]  hdr_off;
    logic [31:0]  hdr_len;
    assign hdr_id  = hdr[127:0];
    assign hdr_off = hdr[159:128];
    assign hdr_len = hdr[191:160];

    logic range_bad, id_bad;
    assign range_bad = ({1'b0, hdr_off} + {1'b0, hdr_len}) > 33'(PAYLOAD_BYTES);
    assign id_bad    = (hdr_id != LOG_ID);

    logic [31:0]                log_size;
    logic [SUPP_BYTES*8-1:0]    supp_vec;
    assign log_size = 32'(entry_count) << 2;
    assign supp_vec = {log_size, LOG_ID, 48'h0, 16'h0001};

    assign log_addr = hdr_off + cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                if (!scan_done)    state_nx = ST_RESP;
                else if (req_kind) state_nx = ST_HDR;
                else               state_nx = ST_SUPP;
            end
            ST_SUPP:  if (cnt == 32'(SUPP_BYTES - 1)) state_nx = ST_RESP;
            ST_HDR:   if (cnt == 32'(HDR_BYTES) && !cap_v) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (range_bad || id_bad || hdr_len == 32'd0) state_nx = ST_RESP;
                else                                         state_nx = ST_COPY;
            end
            ST_COPY:  if (cnt == hdr_len - 32'd1) state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        pl_addr   = cnt[PL_AW-1:0];
        pl_rd_en  = 1'b0;
        pl_wr_en  = 1'b0;
        pl_wdata  = 8'h00;
        unique case (state)
            ST_SUPP: begin
                pl_wr_en = 1'b1;
                pl_wdata = supp_vec[{cnt[4:0], 3'b000} +: 8];
            end
            ST_HDR:  pl_rd_en = (cnt < 32'(HDR_BYTES));
            ST_COPY: begin
                pl_wr_en = 1'b1;
                pl_wdata = log_byte;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            cap_v    <= 1'b0;
            cap_idx  <= '0;
            hdr      <= '0;
            rsp_code <= RC_OK;
            rsp_len  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt   <= '0;
                    cap_v <= 1'b0;
                    if (req_valid && !scan_done) begin
                        rsp_code <= RC_BUSY;
                        rsp_len  <= '0;
                    end
                end
                ST_SUPP: begin
                    cnt <= cnt + 32'd1;
                    if (cnt == 32'(SUPP_BYTES - 1)) begin
                        rsp_code <= RC_OK;
                        rsp_len  <= 16'(SUPP_BYTES);
                    end
                end
                ST_HDR: begin
                    cap_v   <= (cnt < 32'(HDR_BYTES));
                    cap_idx <= cnt[4:0];
                    if (cnt < 32'(HDR_BYTES)) cnt <= cnt + 32'd1;
                    if (cap_v) hdr[{cap_idx, 3'b000} +: 8] <= pl_rdata;
                end
                ST_CHECK: begin
                    cnt     <= '0;
                    rsp_len <= '0;
                    if (range_bad)    rsp_code <= RC_BAD_INPUT;
                    else if (id_bad)  rsp_code <= RC_UNSUPP;
                    else              rsp_code <= RC_OK;
                end
                ST_COPY: begin
                    cnt <= cnt + 32'd1;
                    if (cnt == hdr_len - 32'd1) begin
                        rsp_code <= RC_OK;
                        rsp_len  <= hdr_len[15:0];
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    AST_RSP_PULSE:   assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9
    AST_BUSY_REPLY:  assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !scan_done) |=> (rsp_valid && rsp_code == RC_BUSY && rsp_len == 16'd0)); // R2
    AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_done |-> !pl_wr_en); // R2
    AST_ERR_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != RC_OK) |-> rsp_len == 16'd0); // R6
    AST_RANGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && range_bad) |=> (rsp_valid && rsp_code == RC_BAD_INPUT)); // R6
endmodule

// File: rtl/cel_log_engine.sv
module cel_log_engine
    import cel_pkg::*;
#(
    parameter int N_CMDS = 13,
    parameter logic [N_CMDS*16-1:0] CMD_OPS = {
        16'h4103, 16'h4102, 16'h4100, 16'h4000, 16'h0401, 16'h0400, 16'h0301,
        16'h0300, 16'h0200, 16'h0103, 16'h0102, 16'h0101, 16'h0100},
    parameter logic [N_CMDS*16-1:0] CMD_EFFS = {
        16'h0006, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0008,
        16'h0000, 16'h0000, 16'h0002, 16'h0000, 16'h0010, 16'h0000},
    parameter int LOG_DEPTH = 16,
    parameter int PAYLOAD_BYTES = 256,
    parameter logic [127:0] LOG_ID = 128'h5c3e_91a7_0d4b_4f26_b8e1_7a90_3c52_d6f4,
    localparam int PL_AW = $clog2(PAYLOAD_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_kind,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [7:0]       rsp_code,
    output logic [15:0]      rsp_len,
    output logic [PL_AW-1:0] pl_addr,
    output logic             pl_rd_en,
    input  logic [7:0]       pl_rdata,
    output logic             pl_wr_en,
    output logic [7:0]       pl_wdata
);
    localparam int CW = $clog2(LOG_DEPTH + 1);

    logic [CW-1:0] entry_count;
    logic          scan_done;
    logic [31:0]   log_addr;
    logic [7:0]    log_byte;

    cel_scanner #(
        .N_CMDS(N_CMDS), .CMD_OPS(CMD_OPS), .CMD_EFFS(CMD_EFFS),
        .LOG_DEPTH(LOG_DEPTH)
    ) u_scan (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(log_addr), .rd_byte(log_byte),
        .entry_count(entry_count), .scan_done(scan_done)
    );

    cel_responder #(
        .PAYLOAD_BYTES(PAYLOAD_BYTES), .LOG_ID(LOG_ID), .CW(CW)
    ) u_resp (
        .clk(clk), .rst_n(rst_n),
        .scan_done(scan_done), .entry_count(entry_count),
        .req_valid(req_valid), .req_kind(req_kind), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_len(rsp_len),
        .pl_addr(pl_addr), .pl_rd_en(pl_rd_en), .pl_rdata(pl_rdata),
        .pl_wr_en(pl_wr_en), .pl_wdata(pl_wdata),
        .log_addr(log_addr), .log_byte(log_byte)
    );
endmodule

// File: tb/tb_cel_log_engine.sv
`timescale 1ns/1ps
module tb_cel_log_engine;
    localparam logic [127:0] ID = 128'h5c3e_91a7_0d4b_4f26_b8e1_7a90_3c52_d6f4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_kind = 1'b0;
    logic req_ready, rsp_valid, pl_rd_en, pl_wr_en;
    logic [7:0] rsp_code, pl_wdata;
    logic [7:0] pl_rdata = 8'h00;
    logic [15:0] rsp_len;
    logic [7:0] pl_addr;
    logic tb_we = 1'b0;
    logic [7:0] tb_a = 8'h00, tb_d = 8'h00;
    logic [7:0] mem [256];

    int n_chk = 0, n_bad = 0;
    logic [7:0] got_code;
    logic [15:0] got_len;

    always #2.5 clk = ~clk;

    cel_log_engine dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_len(rsp_len), .pl_addr(pl_addr), .pl_rd_en(pl_rd_en),
        .pl_rdata(pl_rdata), .pl_wr_en(pl_wr_en), .pl_wdata(pl_wdata)
    );

    always @(posedge clk) begin
        if (pl_wr_en) mem[pl_addr] <= pl_wdata;
        else if (tb_we) mem[tb_a] <= tb_d;
        if (pl_rd_en) pl_rdata <= mem[pl_addr];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int idx);
        logic [15:0] op, ef;
        ef = 16'h0;
        case (idx)
            0: op = 16'h0100;  1: begin op = 16'h0101; ef = 16'h0010; end
            2: op = 16'h0102;  3: begin op = 16'h0103; ef = 16'h0002; end
            4: op = 16'h0200;  5: op = 16'h0300;
            6: begin op = 16'h0301; ef = 16'h0008; end
            7: op = 16'h0400;  8: op = 16'h0401;  9: op = 16'h4000;
            10: op = 16'h4100; 11: op = 16'h4102;
            12: begin op = 16'h4103; ef = 16'h0006; end
            default: begin op = 16'h0; ef = 16'h0; end
        endcase
        return {ef, op};
    endfunction

    function automatic logic [7:0] exp_log_byte(input longint a);
        logic [31:0] w;
        w = exp_word(int'(a / 4));
        return w[(a % 4) * 8 +: 8];
    endfunction

    function automatic logic [7:0] fill_pat(input int i, input int salt);
        return 8'((i * 7 + salt) ^ 8'hA5);
    endfunction

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = 8'(a); tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic run_req(input logic kind);
        int t;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
        got_code = rsp_code;
        got_len  = rsp_len;
        chk(rsp_valid, "R9 response pulse", rsp_valid, 1);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R9 single pulse then ready", {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic load_hdr(input logic [127:0] id, input logic [31:0] off,
                            input logic [31:0] len, input int salt);
        for (int i = 0; i < 256; i++) poke(i, fill_pat(i, salt));
        for (int i = 0; i < 16; i++) poke(i, id[i*8 +: 8]);
        for (int i = 0; i < 4; i++) poke(16 + i, off[i*8 +: 8]);
        for (int i = 0; i < 4; i++) poke(20 + i, len[i*8 +: 8]);
    endtask

    task automatic check_untouched(input string req, input int salt);
        bit ok = 1'b1;
        for (int i = 24; i < 256; i++) if (mem[i] !== fill_pat(i, salt)) ok = 1'b0;
        chk(ok, req, 0, 0);
    endtask

    task automatic do_read(input logic [127:0] id, input logic [31:0] off,
                           input logic [31:0] len, input int salt);
        logic [7:0] exp_c;
        load_hdr(id, off, len, salt);
        run_req(1'b1);
        if ({1'b0, off} + {1'b0, len} > 33'd256) exp_c = 8'h02;
        else if (id != ID) exp_c = 8'h03;
        else exp_c = 8'h00;
        if (exp_c == 8'h02) chk(got_code == exp_c, "R6 range code", got_code, exp_c);
        else if (exp_c == 8'h03) chk(got_code == exp_c, "R7 id code", got_code, exp_c);
        else chk(got_code == exp_c, "R8 ok code", got_code, exp_c);
        if (exp_c != 8'h00) begin
            chk(got_len == 16'd0, "R6 R7 zero length", got_len, 0);
            check_untouched("R6 R7 payload untouched", salt);
        end else begin
            bit ok = 1'b1;
            int bad_i = -1;
            chk(got_len == len[15:0], "R8 length", got_len, len);
            for (int i = 0; i < int'(len); i++)
                if (mem[i] !== exp_log_byte(longint'(off) + i)) begin ok = 1'b0; bad_i = i; end
            chk(ok, "R8 R1 copied bytes", bad_i, -1);
            if (len < 256 && len >= 24)
                chk(mem[len] === fill_pat(int'(len), salt), "R8 byte past length",
                    mem[len], fill_pat(int'(len), salt));
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd20240);
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !pl_wr_en, "R9 reset state",
            {req_ready, rsp_valid, pl_wr_en}, 3'b100);

        // requests during the walk
        mem[30] = 8'h77;
        run_req(1'b0);
        chk(got_code == 8'h06 && got_len == 16'd0, "R2 busy on directory query", got_code, 6);
        run_req(1'b1);
        chk(got_code == 8'h06 && got_len == 16'd0, "R2 busy on log read", got_code, 6);
        chk(mem[30] == 8'h77 && mem[0] == 8'h00, "R2 no payload write", mem[30], 8'h77);

        repeat (65600) @(negedge clk);

        // directory query
        run_req(1'b0);
        chk(got_code == 8'h00 && got_len == 16'd28, "R3 code/length", {got_code, got_len}, 28);
        chk(mem[0] == 8'h01 && mem[1] == 8'h00, "R3 count field", {mem[1], mem[0]}, 1);
        begin
            bit ok = 1'b1;
            for (int i = 2; i < 8; i++) if (mem[i] != 8'h00) ok = 1'b0;
            chk(ok, "R3 reserved zero", 0, 0);
            ok = 1'b1;
            for (int i = 0; i < 16; i++) if (mem[8 + i] != ID[i*8 +: 8]) ok = 1'b0;
            chk(ok, "R3 identifier", 0, 0);
        end
        chk({mem[27], mem[26], mem[25], mem[24]} == 32'd52, "R4 log size",
            {mem[27], mem[26], mem[25], mem[24]}, 52);

        // whole log, entry layout and default effects
        do_read(ID, 32'd0, 32'd52, 1);
        chk({mem[7], mem[6], mem[5], mem[4]} == 32'h0010_0101, "R10 clear-records effect",
            {mem[7], mem[6], mem[5], mem[4]}, 32'h0010_0101);
        chk({mem[51], mem[50], mem[49], mem[48]} == 32'h0006_4103, "R10 label-write effect",
            {mem[51], mem[50], mem[49], mem[48]}, 32'h0006_4103);
        chk({mem[27], mem[26], mem[25], mem[24]} == 32'h0008_0301, "R1 ordered entry 6",
            {mem[27], mem[26], mem[25], mem[24]}, 32'h0008_0301);

        // directed corners
        do_read(ID, 32'd200, 32'd57, 2);                 // R6 one over the end
        do_read(~ID, 32'd200, 32'd57, 3);                // R6 priority over id
        do_read(ID, 32'hFFFF_FFF0, 32'h20, 4);           // R6 wrap-around sum
        do_read(ID ^ 128'h1, 32'd0, 32'd4, 5);           // R7 id mismatch
        do_read(ID, 32'd10, 32'd0, 6);                   // R8 zero length
        do_read(ID, 32'd0, 32'd256, 7);                  // R8 exact fit, R5
        do_read(ID, 32'd48, 32'd30, 8);                  // R8 past log end reads zero

        // random mix
        for (int k = 0; k < 30; k++) begin
            int mode;
            logic [31:0] off, len;
            logic [127:0] id;
            mode = int'($urandom % 4);
            id = ID;
            off = $urandom % 80;
            len = 24 + ($urandom % 48);
            if (mode == 1) id = ID ^ (128'h1 << ($urandom % 128));
            if (mode == 2) off = 256 - len + 1 + ($urandom % 16);
            if (mode == 3) off = 256 - len;
            do_read(id, off, len, 10 + k);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule